// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block sends 16-bit words over a synchronous serial line. A write port fills a 15-entry transmit queue, and the block reports how many entries are still free. The line advances one bit on each clock that carries a bit-clock enable. Each frame starts with a single bit period in which the frame-sync output is high and the data line is low. That period is followed by a configurable number of 16-bit slots, each sent most significant bit first. The block takes one word from the queue at the first bit of every slot. If the queue is empty at that moment, the slot carries zeros and the block raises a one-clock underrun pulse.

A frame-sync line from the link partner is compared with the block's own framing on every bit. Whenever the two disagree, the block raises a framing-error pulse. Dropping the enable, or asserting the global power-down input while the stay-awake input is low, stops the transmitter at the end of the word it is sending. The queue keeps its contents, and sending resumes with a fresh frame once the stop condition is gone.

Top module: `sertx_top`

## Requirements
- R1: After reset, sd_out, fs_out, underrun and frame_err are 0 and free_words is 15.
- R2: free_words equals 15 minus the number of queued words. A write with the queue not full is accepted and lowers the count by one. The count changes by at most one per clock.
- R3: A write made while free_words is 0 is dropped. The count stays 0 and the word is never sent.
- R4: A frame is one bit period with fs_out=1 and sd_out=0, followed by cfg_slots+1 slots of 16 bits each, sent most significant bit first. While sending continues, the next frame's sync bit follows the last data bit immediately.
- R5: Slots carry the queued words in write order, one word per slot. A word leaves the queue when its slot's first bit is put on the line.
- R6: If the queue is empty when a slot starts, that slot sends 16 zeros. underrun is then 1 for exactly the clock that follows the bit tick starting that slot. A word written in that same clock is not used for that slot.
- R7: On each bit tick while a frame is in progress, ext_fs must equal fs_out. A mismatch sets frame_err to 1 for the following clock only.
- R8: When pwr_down=1 and sleepless=0, the word being sent completes. After it, the line stays idle (sd_out=0, fs_out=0), no further word leaves the queue, and no new frame starts until the condition clears.
- R9: When sleepless=1, pwr_down has no effect and frames continue.
- R10: A frame starts only when tx_en=1. Clearing tx_en stops sending at the end of the current word, with the same idle behaviour as R8.
- R11: The outputs sd_out and fs_out change only after clocks in which bit_tick=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Bit-clock enable, one clock wide per bit |
| tx_en | input | 1 | Transmitter enable |
| pwr_down | input | 1 | Global power-down request |
| sleepless | input | 1 | When high, pwr_down is ignored |
| cfg_slots | input | SLOT_W (3) | Slots per frame minus one |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 16 | Word to queue |
| ext_fs | input | 1 | Frame sync seen from the link partner |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame sync, one bit period before slot 0 |
| underrun | output | 1 | Pulse: a slot started with the queue empty |
| frame_err | output | 1 | Pulse: ext_fs disagreed with the framing |
| free_words | output | CNT_W (4) | Free queue entries |

## Verification
The properties assume that bit_tick is a one-clock strobe and that a slot start never occurs in two consecutive clocks. They also assume that cfg_slots, tx_en, pwr_down and sleepless are synchronous to clk, and that ext_fs follows fs_out except where an error is injected on purpose. The stimulus changes every input on the falling edge only. It keeps cfg_slots constant while a frame runs, and it produces bit_tick from a divider with periods of one, two and three clocks. ext_fs is generated as fs_out XOR a one-clock inject flag.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              empty;
    } fifo_head_s;

    function automatic logic sync_expected(tx_state_e s);
        return s == ST_SYNC;
    endfunction

    function automatic logic frame_active(tx_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo
    import sertx_pkg::*;
#(
    parameter  int DEPTH = 15,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pop,
    output fifo_head_s        head,
    output logic [CNT_W-1:0]  free_words
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_ok, pop_ok;

    assign push_ok = wr_valid && (count != FULL_CNT);
    assign pop_ok  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head.data  = mem[rd_ptr];
    assign head.empty = (count == '0);
    assign free_words = FULL_CNT - count;

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              go,
    input  logic [SLOT_W-1:0] last_slot,
    input  fifo_head_s        head,
    output logic              pop,
    output logic              sd_out,
    output logic              fs_out,
    output logic              underrun,
    output tx_state_e         state_o
);

    tx_state_e         state, state_nx;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] shreg;
    logic              word_end, load_now;

    always_comb begin
        word_end = (state == ST_SHIFT) && (bit_idx == BIT_LAST);
        load_now = 1'b0;
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (go) state_nx = ST_SYNC;
            end
            ST_SYNC: begin
                load_now = 1'b1;
                state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (word_end) begin
                    if (!go)                    state_nx = ST_IDLE;
                    else if (slot >= last_slot) state_nx = ST_SYNC;
                    else                        load_now = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign pop = bit_tick && load_now && !head.empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            slot     <= '0;
            shreg    <= '0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (bit_tick) begin
                state <= state_nx;
                if (load_now) begin
                    shreg    <= head.empty ? '0 : head.data;
                    underrun <= head.empty;
                    bit_idx  <= '0;
                    slot     <= (state == ST_SYNC) ? '0 : slot + 1'b1;
                end else if (state == ST_SHIFT) begin
                    shreg   <= {shreg[WORD_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    assign sd_out  = (state == ST_SHIFT) ? shreg[WORD_W-1] : 1'b0;
    assign fs_out  = sync_expected(state);
    assign state_o = state;

endmodule

// File: rtl/sertx_fsmon.sv
module sertx_fsmon
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_tick,
    input  tx_state_e state,
    input  logic      ext_fs,
    output logic      frame_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_err <= 1'b0;
        end else begin
            frame_err <= bit_tick && frame_active(state) &&
                         (ext_fs != sync_expected(state));
        end
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter  int DEPTH  = 15,
    parameter  int SLOT_W = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              pwr_down,
    input  logic              sleepless,
    input  logic [SLOT_W-1:0] cfg_slots,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ext_fs,
    output logic              sd_out,
    output logic              fs_out,
    output logic              underrun,
    output logic              frame_err,
    output logic [CNT_W-1:0]  free_words
);

    fifo_head_s head;
    logic       pop;
    logic       go;
    tx_state_e  frm_state;

    assign go = tx_en && !(pwr_down && !sleepless);

    sertx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .pop        (pop),
        .head       (head),
        .free_words (free_words)
    );

    sertx_framer #(.SLOT_W(SLOT_W)) framer_i (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .go        (go),
        .last_slot (cfg_slots),
        .head      (head),
        .pop       (pop),
        .sd_out    (sd_out),
        .fs_out    (fs_out),
        .underrun  (underrun),
        .state_o   (frm_state)
    );

    sertx_fsmon fsmon_i (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .state     (frm_state),
        .ext_fs    (ext_fs),
        .frame_err (frame_err)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter  int DEPTH = 15,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             pwr_down,
    input logic             sleepless,
    input logic             wr_valid,
    input logic             sd_out,
    input logic             fs_out,
    input logic             underrun,
    input logic             frame_err,
    input logic [CNT_W-1:0] free_words,
    input tx_state_e        state
);

    // R2
    free_bound_chk: assert property (@(posedge clk) disable iff (rst)
        free_words <= CNT_W'(DEPTH));

    // R2
    free_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (32'(free_words) + 1 >= 32'($past(free_words))) &&
                 (32'(free_words) <= 32'($past(free_words)) + 1));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (free_words == '0 && wr_valid) |=> (free_words <= CNT_W'(1)));

    // R4
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fs_out |-> !sd_out);

    // R4
    fs_single_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_out && bit_tick) |=> !fs_out);

    // R6
    underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

    // R7
    ferr_tick_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(bit_tick));

    // R8
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && pwr_down && !sleepless) |=> (state == ST_IDLE));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(sd_out) && $stable(fs_out)));

endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .pwr_down   (pwr_down),
    .sleepless  (sleepless),
    .wr_valid   (wr_valid),
    .sd_out     (sd_out),
    .fs_out     (fs_out),
    .underrun   (underrun),
    .frame_err  (frame_err),
    .free_words (free_words),
    .state      (frm_state)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/100ps
module sertx_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_tick;
    logic        tx_en, pwr_down, sleepless;
    logic [2:0]  cfg_slots;
    logic        wr_valid;
    logic [15:0] wr_data;
    logic        ext_fs;
    logic        inject;
    logic        sd_out, fs_out, underrun, frame_err;
    logic [3:0]  free_words;

    int n_chk  = 0;
    int n_fail = 0;
    int div    = 1;
    int tcnt   = 0;

    always #2.5 clk = ~clk;

    assign ext_fs = fs_out ^ inject;

    sertx_top dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en),
        .pwr_down(pwr_down), .sleepless(sleepless), .cfg_slots(cfg_slots),
        .wr_valid(wr_valid), .wr_data(wr_data), .ext_fs(ext_fs),
        .sd_out(sd_out), .fs_out(fs_out), .underrun(underrun),
        .frame_err(frame_err), .free_words(free_words)
    );

    always @(negedge clk) begin
        if (rst) begin
            tcnt     <= 0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= (tcnt == 0);
            tcnt     <= (tcnt + 1 >= div) ? 0 : tcnt + 1;
        end
    end

    typedef struct packed {
        logic [2:0]  cfg;
        logic [3:0]  nw;
        logic [1:0]  dv;
        logic [15:0] seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{cfg: 3'd0, nw: 4'd1, dv: 2'd1, seed: 16'hA5C3},
        '{cfg: 3'd1, nw: 4'd2, dv: 2'd1, seed: 16'h1234},
        '{cfg: 3'd3, nw: 4'd4, dv: 2'd2, seed: 16'hF00F},
        '{cfg: 3'd2, nw: 4'd1, dv: 2'd1, seed: 16'h8001},
        '{cfg: 3'd7, nw: 4'd8, dv: 2'd3, seed: 16'h0F0F},
        '{cfg: 3'd4, nw: 4'd0, dv: 2'd1, seed: 16'h7777}
    };

    function automatic logic [15:0] word_of(logic [15:0] seed, int i);
        return seed + 16'(i) * 16'h1F3B;
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_en = 1'b0; pwr_down = 1'b0; sleepless = 1'b0;
        cfg_slots = '0; wr_valid = 1'b0; wr_data = '0; inject = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [15:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic next_bit();
        logic t;
        do begin
            @(posedge clk);
            t = bit_tick;
            @(negedge clk);
        end while (!t);
    endtask

    task automatic wait_fs();
        int lim = 0;
        do begin
            next_bit();
            lim++;
        end while (!fs_out && lim < 2000);
        chk(fs_out, "R4 frame sync seen", 32'(fs_out), 32'd1);
        chk(!sd_out, "R4 data low during sync", 32'(sd_out), 32'd0);
    endtask

    task automatic get_word(output logic [15:0] w, output logic ur);
        logic v;
        w  = '0;
        ur = 1'b0;
        for (int i = 0; i < 16; i++) begin
            next_bit();
            if (i == 0) ur = underrun;
            w = {w[14:0], sd_out};
            if (div > 1) begin
                v = sd_out;
                @(negedge clk);
                chk(sd_out == v, "R11 hold between ticks", 32'(sd_out), 32'(v));
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic        ur;
        logic        seen;

        // R1 reset state
        do_reset();
        chk(sd_out == 0, "R1 sd_out", 32'(sd_out), 0);
        chk(fs_out == 0, "R1 fs_out", 32'(fs_out), 0);
        chk(underrun == 0, "R1 underrun", 32'(underrun), 0);
        chk(frame_err == 0, "R1 frame_err", 32'(frame_err), 0);
        chk(free_words == 15, "R1 free_words", 32'(free_words), 15);

        // table-driven frames: R2 R4 R5 R6 R10 R11
        foreach (VECS[k]) begin
            do_reset();
            div = int'(VECS[k].dv);
            cfg_slots = VECS[k].cfg;
            for (int i = 0; i < int'(VECS[k].nw); i++) wr_word(word_of(VECS[k].seed, i));
            @(negedge clk);
            chk(free_words == 4'd15 - VECS[k].nw, "R2 free count",
                32'(free_words), 32'(4'd15 - VECS[k].nw));
            chk(!fs_out, "R10 idle before enable", 32'(fs_out), 0);
            tx_en = 1'b1;
            wait_fs();
            for (int s = 0; s <= int'(VECS[k].cfg); s++) begin
                get_word(w, ur);
                if (s < int'(VECS[k].nw)) begin
                    chk(w == word_of(VECS[k].seed, s), "R5 slot word",
                        32'(w), 32'(word_of(VECS[k].seed, s)));
                    chk(!ur, "R6 no underrun", 32'(ur), 0);
                end else begin
                    chk(w == 16'h0, "R6 zero slot", 32'(w), 0);
                    chk(ur, "R6 underrun pulse", 32'(ur), 1);
                end
            end
            next_bit();
            chk(fs_out, "R4 back-to-back sync", 32'(fs_out), 1);
            tx_en = 1'b0;
            repeat (20) next_bit();
            seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                next_bit();
                if (fs_out || sd_out) seen = 1'b1;
            end
            chk(!seen, "R10 stopped after disable", 32'(seen), 0);
        end
        div = 1;

        // R3 full queue drops writes
        do_reset();
        cfg_slots = 3'd7;
        for (int i = 0; i < 15; i++) wr_word(word_of(16'h3C5A, i));
        @(negedge clk);
        chk(free_words == 0, "R3 full after 15", 32'(free_words), 0);
        wr_word(16'hDEAD);
        @(negedge clk);
        chk(free_words == 0, "R3 count after dropped write", 32'(free_words), 0);
        tx_en = 1'b1;
        for (int f = 0; f < 2; f++) begin
            wait_fs();
            for (int s = 0; s < 8; s++) begin
                get_word(w, ur);
                if (f * 8 + s < 15) begin
                    chk(w == word_of(16'h3C5A, f * 8 + s), "R5 order after fill",
                        32'(w), 32'(word_of(16'h3C5A, f * 8 + s)));
                end else begin
                    chk(w == 0 && ur, "R3 dropped word never sent", 32'({ur, w}), 32'h10000);
                end
            end
        end
        tx_en = 1'b0;

        // R7 framing error pulses
        do_reset();
        cfg_slots = 3'd1;
        wr_word(16'h1111);
        wr_word(16'h2222);
        tx_en = 1'b1;
        wait_fs();
        chk(!frame_err, "R7 quiet on matching sync", 32'(frame_err), 0);
        repeat (3) next_bit();
        inject = 1'b1;
        @(negedge clk);
        inject = 1'b0;
        chk(frame_err, "R7 spurious sync flagged", 32'(frame_err), 1);
        @(negedge clk);
        chk(!frame_err, "R7 pulse one clock", 32'(frame_err), 0);
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            next_bit();
            if (fs_out) seen = 1'b1;
        end
        inject = 1'b1;
        @(negedge clk);
        inject = 1'b0;
        chk(frame_err, "R7 missing sync flagged", 32'(frame_err), 1);
        tx_en = 1'b0;

        // R8 power-down completes current word
        do_reset();
        cfg_slots = 3'd3;
        for (int i = 0; i < 4; i++) wr_word(word_of(16'h6B2D, i));
        tx_en = 1'b1;
        wait_fs();
        w = '0;
        for (int i = 0; i < 16; i++) begin
            if (i == 5) pwr_down = 1'b1;
            next_bit();
            w = {w[14:0], sd_out};
        end
        chk(w == word_of(16'h6B2D, 0), "R8 word completes", 32'(w), 32'(word_of(16'h6B2D, 0)));
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            next_bit();
            if (fs_out || sd_out) seen = 1'b1;
        end
        chk(!seen, "R8 line idle", 32'(seen), 0);
        chk(free_words == 12, "R8 queue untouched", 32'(free_words), 12);
        pwr_down = 1'b0;
        wait_fs();
        get_word(w, ur);
        chk(w == word_of(16'h6B2D, 1), "R8 resumes with next word", 32'(w), 32'(word_of(16'h6B2D, 1)));
        tx_en = 1'b0;

        // R9 sleepless ignores power-down
        do_reset();
        sleepless = 1'b1;
        pwr_down = 1'b1;
        cfg_slots = 3'd1;
        wr_word(16'hBEEF);
        wr_word(16'h0F1E);
        tx_en = 1'b1;
        wait_fs();
        get_word(w, ur);
        chk(w == 16'hBEEF, "R9 slot0 sent", 32'(w), 32'hBEEF);
        get_word(w, ur);
        chk(w == 16'h0F1E, "R9 slot1 sent", 32'(w), 32'h0F1E);
        next_bit();
        chk(fs_out, "R9 frames continue", 32'(fs_out), 1);
        tx_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule